// File: doc/BRIEF.md
# LCD Row-Scan Common Driver Core

This block is the logic core of a row (common) driver for a dot-matrix LCD panel with 64 rows. A scan token arrives on a serial input, passes a level-controlled transparent latch, and enters a 64-stage shift register. The register advances on the falling edge of the row clock, and stage k drives row k. Each row output is a 2-bit code that picks one of four drive levels. The code comes from the stage bit, the frame polarity (AC inversion) input and an active-low blanking input. The last stage is presented on a serial output, so a second driver on the same clock can continue the scan for panels with deeper duty cycles.

In normal use the controller raises the serial input with the latch open once per frame. The single 1 then steps through rows 0 to 63, one row per clock. The register is built from parameterised segments (two segments of 32 stages by default) chained in series. Level shifting and drive voltages lie outside this core.

Top module: `lcd_row_scan_top`

## Requirements
- R1: While `rst` is high, the input latch reads 0, and a falling clock edge clears every stage. After reset every row shows the non-select code for the current polarity, and `ser_out` is 0.
- R2: On each falling edge of `clk` with `rst` low, stage k+1 takes the old value of stage k, and stage 0 takes the latch output. Stage k drives `row_lvl[2k+1:2k]`.
- R3: While `latch_en` is high, the latch output follows `ser_in`.
- R4: While `latch_en` is low, the latch keeps its last value, so that value keeps entering stage 0 on every falling edge.
- R5: `ser_out` equals stage 63 and changes only on a falling clock edge, never in response to changes on the other inputs.
- R6: A row whose bit is 1 and that is not blanked drives code 2'b11 (lowest rail) when `frame_pol` is 0, and 2'b00 (highest rail) when `frame_pol` is 1.
- R7: A row whose bit is 0 drives code 2'b01 (upper middle level) when `frame_pol` is 0, and 2'b10 (lower middle level) when `frame_pol` is 1.
- R8: While `blank_n` is low, every row drives the R7 code for the current `frame_pol`, whatever the register holds. The register contents are not lost.
- R9: A single token loaded into stage 0 reaches stage 63, and so `ser_out`, after 64 falling edges in total, crossing the internal segment boundary unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Row shift clock; the register advances on its falling edge |
| rst | input | 1 | Active-high reset; clears the latch and, at a falling edge, the stages |
| latch_en | input | 1 | Input latch control: high is transparent, low holds |
| ser_in | input | 1 | Serial scan data in |
| frame_pol | input | 1 | AC-inversion frame polarity |
| blank_n | input | 1 | Active-low display blanking |
| ser_out | output | 1 | Last stage, for a cascaded driver |
| row_lvl | output | 128 | Two-bit level code per row; row k in bits [2k+1:2k] |

## Verification
A corrupted stage shows up as a wrong level code on its own row within the same half-period. It then moves one row per falling edge until it leaves through `ser_out`. A lost or duplicated token is visible at the ports within at most 64 edges. A latch that does not hold or does not follow shows up one falling edge later, as a wrong code on row 0. A fault in the polarity or blanking path appears at once on every row, because the encoder is combinational. The bench therefore compares every row code and `ser_out` both before and after each falling edge.

// File: rtl/lcd_row_pkg.sv
package lcd_row_pkg;

    typedef enum logic [1:0] {
        LVL_TOP  = 2'b00,
        LVL_MIDH = 2'b01,
        LVL_MIDL = 2'b10,
        LVL_BOT  = 2'b11
    } drv_lvl_e;

endpackage

// File: rtl/lcd_row_shreg.sv
module lcd_row_shreg #(
    parameter int LEN = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_in,
    output logic [LEN-1:0] stages_o
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } seg_state_t;

    seg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.bits = '0;
        end else begin
            state_d.bits = {state_q.bits[LEN-2:0], shift_in};
        end
    end

    always_ff @(negedge clk) begin
        state_q <= state_d;
    end

    assign stages_o = state_q.bits;

    // R2: the first stage captures what was on the input before the edge
    assert_entry_R2: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> state_q.bits[0] == $past(shift_in));

    generate
        for (genvar k = 1; k < LEN; k++) begin : g_shift_chk
            assert_stage_shift_R2: assert property (@(negedge clk) disable iff (rst)
                !$past(rst) |-> state_q.bits[k] == $past(state_q.bits[k-1]));
        end
    endgenerate

endmodule

// File: rtl/lcd_row_lvl_enc.sv
module lcd_row_lvl_enc
    import lcd_row_pkg::*;
(
    input  logic       sel_i,
    input  logic       fr_i,
    input  logic       blank_n_i,
    output logic [1:0] lvl_o
);

    drv_lvl_e lvl;

    always_comb begin
        if (sel_i && blank_n_i) begin
            lvl = fr_i ? LVL_TOP : LVL_BOT;
        end else begin
            lvl = fr_i ? LVL_MIDL : LVL_MIDH;
        end
    end

    assign lvl_o = lvl;

endmodule

// File: rtl/lcd_row_scan_top.sv
module lcd_row_scan_top
    import lcd_row_pkg::*;
#(
    parameter int SEG_LEN  = 32,
    parameter int NUM_SEGS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          latch_en,
    input  logic                          ser_in,
    input  logic                          frame_pol,
    input  logic                          blank_n,
    output logic                          ser_out,
    output logic [2*SEG_LEN*NUM_SEGS-1:0] row_lvl
);

    localparam int NUM_ROWS = SEG_LEN * NUM_SEGS;

    logic                lat_q;
    logic [NUM_ROWS-1:0] all_stages;
    logic [NUM_SEGS:0]   seg_link;

    // Transparent input latch; reset forces it to 0 while asserted
    always_latch begin
        if (rst) begin
            lat_q = 1'b0;
        end else if (latch_en) begin
            lat_q = ser_in;
        end
    end

    assign seg_link[0] = lat_q;

    generate
        for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
            logic [SEG_LEN-1:0] seg_bits;
            lcd_row_shreg #(.LEN(SEG_LEN)) u_seg (
                .clk      (clk),
                .rst      (rst),
                .shift_in (seg_link[s]),
                .stages_o (seg_bits)
            );
            assign all_stages[s*SEG_LEN +: SEG_LEN] = seg_bits;
            assign seg_link[s+1] = seg_bits[SEG_LEN-1];
        end
    endgenerate

    assign ser_out = seg_link[NUM_SEGS];

    generate
        for (genvar k = 0; k < NUM_ROWS; k++) begin : g_row
            lcd_row_lvl_enc u_enc (
                .sel_i     (all_stages[k]),
                .fr_i      (frame_pol),
                .blank_n_i (blank_n),
                .lvl_o     (row_lvl[2*k +: 2])
            );

            // R8: while blanked no row may sit on an outer rail
            assert_blank_R8: assert property (@(posedge clk) disable iff (rst)
                !blank_n |-> (row_lvl[2*k +: 2] != LVL_TOP && row_lvl[2*k +: 2] != LVL_BOT));

            // R6: an outer rail appears only for a set, unblanked stage
            assert_select_R6: assert property (@(posedge clk) disable iff (rst)
                (row_lvl[2*k +: 2] == LVL_TOP || row_lvl[2*k +: 2] == LVL_BOT)
                    |-> (all_stages[k] && blank_n));
        end
    endgenerate

    // R9: tokens are conserved: one may enter at stage 0 and one leave past the end
    assert_token_count_R9: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> $countones(all_stages) ==
            $countones($past(all_stages)) - int'($past(ser_out)) + int'($past(lat_q)));

endmodule

// File: tb/lcd_row_scan_top_bench.sv
`timescale 1ns/1ps
module lcd_row_scan_top_bench;

    localparam int NR = 64;

    logic          clk = 1'b0;
    logic          rst, latch_en, ser_in, frame_pol, blank_n;
    logic          ser_out;
    logic [2*NR-1:0] row_lvl;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  mdl_q[$];
    bit  mdl_lat;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    lcd_row_scan_top u_lcd_row_scan_top (
        .clk       (clk),
        .rst       (rst),
        .latch_en  (latch_en),
        .ser_in    (ser_in),
        .frame_pol (frame_pol),
        .blank_n   (blank_n),
        .ser_out   (ser_out),
        .row_lvl   (row_lvl)
    );

    function automatic logic [1:0] exp_code(bit s, logic fr, logic bn);
        if (s && bn) return fr ? 2'b00 : 2'b11;
        return fr ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [2*NR-1:0] exp_rows();
        logic [2*NR-1:0] v;
        for (int k = 0; k < NR; k++) v[2*k +: 2] = exp_code(mdl_q[k], frame_pol, blank_n);
        return v;
    endfunction

    task automatic chk(input string req, input logic [2*NR-1:0] act, input logic [2*NR-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One row-clock period: drive away from the falling edge, compare before and after it
    task automatic step(input logic r, input logic le, input logic d,
                        input logic fr, input logic bn, input string req);
        logic so_before;
        so_before = ser_out;
        rst = r; latch_en = le; ser_in = d; frame_pol = fr; blank_n = bn;
        #1;
        if (r) mdl_lat = 1'b0;
        else if (le) mdl_lat = d;
        chk(req, row_lvl, exp_rows());
        chk("R5", {127'b0, ser_out}, {127'b0, so_before});
        @(negedge clk);
        if (r) begin
            for (int k = 0; k < NR; k++) mdl_q[k] = 1'b0;
        end else begin
            mdl_q.push_front(mdl_lat);
            void'(mdl_q.pop_back());
        end
        #2;
        chk(req, row_lvl, exp_rows());
        chk("R5", {127'b0, ser_out}, {127'b0, logic'(mdl_q[NR-1])});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; latch_en = 1'b0; ser_in = 1'b0; frame_pol = 1'b0; blank_n = 1'b1;
        for (int k = 0; k < NR; k++) mdl_q.push_back(1'b0);
        mdl_lat = 1'b0;
        @(negedge clk); #2;
        @(negedge clk); #2;
        step(1, 1, 1, 0, 1, "R1");
        // R1: all rows non-select for polarity 0, serial out low
        chk("R1", row_lvl, {NR{2'b01}});
        chk("R1", {127'b0, ser_out}, 128'b0);

        // R2 R9: one token walks the full register, polarity alternating (R6 R7)
        step(0, 1, 1, 0, 1, "R2");
        for (int i = 0; i < 70; i++) begin
            step(0, 1, 0, logic'(i % 2), 1, "R9");
            if (i == 62) chk("R9", {127'b0, ser_out}, 128'b1);
        end

        // R6: a set row with polarity 1 drives the highest rail
        step(0, 1, 1, 1, 1, "R6");
        chk("R6", {126'b0, row_lvl[1:0]}, {126'b0, 2'b00});
        // R7: clear rows with polarity 1
        chk("R7", {126'b0, row_lvl[3:2]}, {126'b0, 2'b10});

        // R4: latch closed after loading a 1, input driven low
        step(0, 1, 1, 0, 1, "R3");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R4");
        chk("R4", {116'b0, row_lvl[11:0]}, {116'b0, 12'hFFF});

        // R3: open latch with an alternating data pattern
        for (int i = 0; i < 20; i++) step(0, 1, logic'((i / 3) % 2), logic'(i % 3 == 0), 1, "R3");

        // R8: blanking hides data under both polarities
        step(0, 1, 1, 1, 0, "R8");
        chk("R8", row_lvl, {NR{2'b10}});
        step(0, 1, 1, 0, 0, "R8");
        chk("R8", row_lvl, {NR{2'b01}});
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, "R8");
        // R8: contents intact once blanking is released
        step(0, 1, 0, 1, 1, "R8");

        // R1: reset in the middle of content
        step(1, 1, 1, 1, 1, "R1");
        chk("R1", row_lvl, {NR{2'b10}});
        chk("R1", {127'b0, ser_out}, 128'b0);
        step(0, 0, 1, 0, 1, "R4");
        chk("R4", row_lvl, {NR{2'b01}});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule